// File: doc/BRIEF.md
# Indexed Block-Access Serial Register Target

This block is the target side of a two-wire serial bus in the SMBus/I2C style. It gives a host access to a bank of sixteen 8-bit configuration registers. It watches oversampled clock and data lines and answers one 7-bit address. One address bit comes from a select pin, so two of these blocks can share a bus. It pulls the data line low through an open-drain enable, and it shows the whole register bank on a flat output vector for the logic around it.

Every access is an indexed block transfer.

- **Write:** the host sends the write address, a starting index, a byte count and then that many data bytes. These bytes land in consecutive registers.
- **Read:** the host sends the write address and the starting index. It then issues a repeated start with the read address. The block answers with a count byte and then consecutive register bytes. The count byte is the value of a dedicated count register at index 8, so the length of a read is set by that register and not by the host alone.

Top module: `smb_idxblk_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 0x68 when `addr_sel` is low, or 0x69 when it is high. These are bytes D0/D1 and D2/D3, differing in bit 1. Any other address is not acknowledged, and the block ignores the rest of that transfer.
- R2: A write transfer (address byte bit 0 = 0, then index N, then count X, then X data bytes) stores the data bytes into registers N, N+1, … in order.
- R3: The block pulls SDA low during the ninth clock after each of these bytes: a matching address, the index, the count, and each data byte inside the count.
- R4: After a repeated start and a read address (bit 0 = 1), the first byte shifted out MSB first is the content of register 8. The bytes that follow are registers N, N+1, … for as long as the host acknowledges.
- R5: After reset, register 8 holds 8, every other register holds 0, and SDA is released.
- R6: Register indices wrap modulo 16, for writes and for reads.
- R7: The block changes its SDA drive only while SCL is low.
- R8: A stop seen in the middle of a byte abandons that byte without writing any register.
- R9: When the host does not acknowledge a read byte, the block releases SDA and drives nothing until the next start.
- R10: A count of 0 updates no register, but the count byte is still acknowledged. A data byte sent beyond the count is not acknowledged and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 1 | Selects address bit 1 (D0/D1 or D2/D3) |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| regs_o | output | 128 | Register bank, register k at bits 8k+7..8k |

## Verification
The write path is driven with several patterns:

- a block placed in the middle of the bank;
- a block that runs past index 15, which separates true wrapping from clamping or spilling;
- a zero count followed by a stray byte, which separates counting from plain acknowledging.

Address handling is tried with both select levels against both address bytes, so a swapped or ignored select bit shows up as a wrong acknowledge. Reads are run from a middle index and from index 15, with the count register reprogrammed first, so the bench can tell a count byte taken from register 8 from one taken from the start index. Clocking on after a host not-acknowledge, and a stop in the middle of a byte, show whether the block really lets go.

// File: rtl/smb_idxblk_slave.sv
module smb_idxblk_slave #(
  parameter int         NREG      = 16,
  parameter int         CNT_IDX   = 8,
  parameter logic [7:0] CNT_RST   = 8'd8,
  parameter logic [6:0] BASE_ADDR = 7'h68
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            addr_sel,
  output logic            sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IW = $clog2(NREG);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_RX = 3'd1, S_ACK = 3'd2, S_TX = 3'd3, S_RACK = 3'd4, S_WAIT = 3'd5
  } st_t;
  typedef enum logic [1:0] {K_ADDR, K_IDX, K_CNT, K_DATA} kind_t;

  logic [2:0]    scl_p, sda_p;
  logic [7:0]    bank [NREG];
  st_t           st;
  kind_t         kind;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txsh, wleft;
  logic [IW-1:0] ptr;
  logic          rdmode;

  wire scl_rise  = scl_p[1] & ~scl_p[2];
  wire scl_fall  = ~scl_p[1] & scl_p[2];
  wire start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire [6:0] my_addr = {BASE_ADDR[6:1], BASE_ADDR[0] | addr_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      kind   <= K_ADDR;
      bitcnt <= '0;
      shreg  <= '0;
      txsh   <= '0;
      wleft  <= '0;
      ptr    <= '0;
      rdmode <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) bank[i] <= (i == CNT_IDX) ? CNT_RST : 8'd0;
    end else if (start_det) begin
      st     <= S_RX;
      kind   <= K_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_p[1]};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            st     <= S_ACK;
            sda_oe <= 1'b1;
            bitcnt <= '0;
            case (kind)
              K_ADDR: begin
                if (shreg[7:1] != my_addr) begin
                  st     <= S_IDLE;
                  sda_oe <= 1'b0;
                end else begin
                  rdmode <= shreg[0];
                  kind   <= K_IDX;
                end
              end
              K_IDX: begin
                ptr  <= shreg[IW-1:0];
                kind <= K_CNT;
              end
              K_CNT: begin
                wleft <= shreg;
                kind  <= K_DATA;
              end
              default: begin
                if (wleft == 8'd0) begin
                  st     <= S_WAIT;
                  sda_oe <= 1'b0;
                end else begin
                  bank[ptr] <= shreg;
                  ptr       <= ptr + 1'b1;
                  wleft     <= wleft - 8'd1;
                end
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rdmode) begin
              txsh   <= bank[CNT_IDX];
              sda_oe <= ~bank[CNT_IDX][7];
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= S_RACK;
            end else begin
              txsh   <= {txsh[6:0], 1'b0};
              sda_oe <= ~txsh[6];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            if (sda_p[1]) st <= S_WAIT;
            else          bitcnt <= 4'd1;
          end else if (scl_fall && bitcnt == 4'd1) begin
            txsh   <= bank[ptr];
            sda_oe <= ~bank[ptr][7];
            ptr    <= ptr + 1'b1;
            bitcnt <= '0;
            st     <= S_TX;
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*8 +: 8] = bank[g];
  end
endmodule

// File: rtl/smb_idxblk_chk.sv
module smb_idxblk_chk #(
  parameter logic [7:0] CNT_RST = 8'd8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [2:0] st,
  input logic       start_det,
  input logic [7:0] cnt_val
);
  localparam logic [2:0] C_IDLE = 3'd0, C_RX = 3'd1, C_ACK = 3'd2, C_WAIT = 3'd5;

  a_r5_count_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cnt_val == CNT_RST && !sda_oe));

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE) |-> !sda_oe);

  a_r3_ack_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_ACK) |-> sda_oe);

  a_r9_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_WAIT) |-> !sda_oe);

  a_r8_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == C_RX));

  a_r7_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> $stable(sda_oe));
endmodule

bind smb_idxblk_slave smb_idxblk_chk #(.CNT_RST(CNT_RST)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .st       (st),
  .start_det(start_det),
  .cnt_val  (regs_o[CNT_IDX*8 +: 8])
);

// File: tb/smb_idxblk_slave_tb.sv
module smb_idxblk_slave_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_oe;
  logic [127:0] regs_o;
  wire  sda_bus = host_sda & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] expb [16];
  logic [7:0] wbuf [4];

  always #10 clk = ~clk;

  smb_idxblk_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .regs_o(regs_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_flat();
    logic [127:0] f;
    for (int i = 0; i < 16; i++) f[i*8 +: 8] = expb[i];
    return f;
  endfunction

  task automatic h_start();
    host_sda = 1'b1; tick(Q); host_scl = 1'b1; tick(Q);
    host_sda = 1'b0; tick(Q); host_scl = 1'b0; tick(Q);
  endtask

  task automatic h_stop();
    host_sda = 1'b0; tick(Q); host_scl = 1'b1; tick(Q);
    host_sda = 1'b1; tick(2*Q);
  endtask

  task automatic h_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      host_sda = b[i]; tick(Q); host_scl = 1'b1; tick(2*Q); host_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic h_byte(input logic [7:0] b, output logic ack);
    h_bits(b, 8);
    host_sda = 1'b1; tick(Q); host_scl = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q); host_scl = 1'b0; tick(Q);
  endtask

  task automatic h_read(input logic nack, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); host_scl = 1'b1; tick(Q); b[i] = sda_bus; tick(Q); host_scl = 1'b0; tick(Q);
    end
    host_sda = nack; tick(Q); host_scl = 1'b1; tick(2*Q); host_scl = 1'b0; tick(Q);
    host_sda = 1'b1;
  endtask

  task automatic blk_write(input logic [7:0] adr, input logic [7:0] idx, input logic [7:0] cnt,
                           input string req);
    logic a;
    h_start();
    h_byte(adr, a);  chk({"R3 address ack ", req}, a, 1'b1);
    h_byte(idx, a);  chk({"R3 index ack ", req}, a, 1'b1);
    h_byte(cnt, a);  chk({"R3 count ack ", req}, a, 1'b1);
    for (int i = 0; i < int'(cnt); i++) begin
      h_byte(wbuf[i], a);
      chk({"R3 data ack ", req}, a, 1'b1);
      expb[(int'(idx) + i) % 16] = wbuf[i];
    end
    h_stop();
  endtask

  task automatic t_reset();
    chk("R5 sda released after reset", sda_oe, 1'b0);
    chk("R5 reset bank contents", regs_o, exp_flat());
  endtask

  task automatic t_write_basic();
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    blk_write(8'hD0, 8'd2, 8'd3, "basic");
    chk("R2 block write regs 2..4", regs_o, exp_flat());
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    blk_write(8'hD0, 8'd14, 8'd4, "wrap");
    chk("R6 write wraps 14,15,0,1", regs_o, exp_flat());
  endtask

  task automatic t_addr_select();
    logic a;
    addr_sel = 1'b0;
    h_start();
    h_byte(8'hD2, a); chk("R1 D2 refused with select low", a, 1'b0);
    h_byte(8'h05, a); h_byte(8'h01, a); h_byte(8'h77, a);
    chk("R1 bytes after refused address not acked", a, 1'b0);
    h_stop();
    chk("R1 bank untouched by foreign address", regs_o, exp_flat());
    addr_sel = 1'b1; tick(Q);
    wbuf[0] = 8'h5A;
    blk_write(8'hD2, 8'd7, 8'd1, "select high");
    chk("R1 write through D2 with select high", regs_o, exp_flat());
    h_start();
    h_byte(8'hD0, a); chk("R1 D0 refused with select high", a, 1'b0);
    h_stop();
    addr_sel = 1'b0; tick(Q);
  endtask

  task automatic t_zero_count();
    logic a;
    blk_write(8'hD0, 8'd5, 8'd0, "zero count");
    h_start();
    h_byte(8'hD0, a); h_byte(8'd5, a); h_byte(8'd0, a);
    chk("R10 zero count acked", a, 1'b1);
    h_byte(8'hEE, a);
    chk("R10 byte past count refused", a, 1'b0);
    h_stop();
    chk("R10 bank unchanged by zero count", regs_o, exp_flat());
  endtask

  task automatic t_abort();
    logic a;
    h_start();
    h_byte(8'hD0, a); h_byte(8'd9, a); h_byte(8'd2, a);
    h_byte(8'h66, a); chk("R3 first data ack before abort", a, 1'b1);
    expb[9] = 8'h66;
    h_bits(8'hFF, 4);
    h_stop();
    chk("R8 stop mid-byte commits nothing", regs_o, exp_flat());
    chk("R8 sda released after abort", sda_oe, 1'b0);
  endtask

  task automatic t_read(input logic [7:0] idx, input string req);
    logic a;
    logic [7:0] b;
    h_start();
    h_byte(8'hD0, a); h_byte(idx, a);
    h_start();
    h_byte(8'hD1, a); chk({"R3 read address ack ", req}, a, 1'b1);
    h_read(1'b0, b);  chk({"R4 count byte ", req}, b, expb[8]);
    for (int i = 0; i < int'(expb[8]); i++) begin
      h_read(i == int'(expb[8]) - 1, b);
      chk({"R4 R6 read data ", req}, b, expb[(int'(idx) + i) % 16]);
    end
    chk({"R9 released after nack ", req}, sda_oe, 1'b0);
    h_read(1'b1, b);
    chk({"R9 no drive after nack ", req}, b, 8'hFF);
    h_stop();
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) expb[i] = (i == 8) ? 8'd8 : 8'd0;
    tick(5); rst_n = 1'b1; tick(5);
    t_reset();
    t_write_basic();
    t_wrap();
    t_addr_select();
    t_zero_count();
    t_abort();
    wbuf[0] = 8'd3;
    blk_write(8'hD0, 8'd8, 8'd1, "set count");
    t_read(8'd2, "mid");
    t_read(8'd15, "wrap");
    report();
    $finish;
  end
endmodule